// File: doc/BRIEF.md
# Pointer-Addressed Packet Buffer Port

This block lets a host bus reach a 2048-byte packet buffer through a small register window instead of a wide address bus. The host sets an 11-bit address pointer in two byte writes. It then moves data one byte at a time through a single data register. An optional auto-increment lets a whole packet be streamed with repeated accesses to that register. Afterwards the host can read the pointer back to see how far the transfer got.

Host accesses never wait on the memory. A read returns the byte already held in a holding register, and that register is refilled ahead of time by a prefetch. A write lands in the same holding register and is committed to memory later. The memory is shared with a network-side requester through a fixed-priority arbiter. Arbitration slots occur on every clock or, when the slow setting is chosen, on every second clock.

The host register window is selected by `host_sel`:
- 0: data
- 1: pointer low byte
- 2: pointer high byte
- 3: setup

Top module: `pbuf_port`

## Requirements
- R1: After reset, the pointer high and low readbacks, the setup register and `busy` all read 0.
- R2: A write to the pointer high byte (select 2) only stages its contents. The pointer address and control readback stay unchanged until the following write to the pointer low byte (select 1). That low-byte write loads address = {staged high bits [2:0], low byte} and takes the control bits into effect.
- R3: In the pointer high byte, bit 7 set means read direction. When the low-byte write loads a pointer with read direction, the block fetches the addressed byte into the holding register within one free arbitration slot. With one idle clock after the load, the next data read returns that byte.
- R4: With auto-increment on (high byte bit 6), each data-register read returns the byte at the pointer, advances the pointer by one and prefetches the next byte. Back-to-back reads therefore stream consecutive bytes.
- R5: Each data-register write is staged and committed to the pointer address in the next free slot. It sets `busy` until the commit is done. With auto-increment on, the pointer advances by one.
- R6: With auto-increment off, data-register accesses leave the pointer unchanged.
- R7: When auto-increment advances past address 0x7FF, the pointer wraps to 0x000.
- R8: A network request in a slot always wins. A pending host prefetch or commit waits, with `busy` high, until a slot with no network request.
- R9: Setup bit 0 set selects slow arbitration. Slots, and so network grants, then occur on alternate clocks only. With the bit clear, every clock is a slot.
- R10: Pointer readback (high byte: bit 7 direction, bit 6 auto-increment, bits 2:0 address bits 10:8; low byte: address bits 7:0) gives the address reached after a transfer.
- R11: A network access is performed in the granted cycle. Write data is stored, and read data appears on `net_rdata` after the next clock edge.
- R12: A low-byte write that loads a pointer with write direction (bit 7 clear) starts no prefetch, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 2 | Host register select: 0 data, 1 pointer low, 2 pointer high, 3 setup |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for the selected register |
| busy | output | 1 | Host prefetch or commit pending at the arbiter |
| net_req | input | 1 | Network-side access request |
| net_we | input | 1 | Network-side write enable |
| net_addr | input | 11 | Network-side byte address |
| net_wdata | input | 8 | Network-side write data |
| net_gnt | output | 1 | Network access performed this cycle |
| net_rdata | output | 8 | Network read data, valid after the granted cycle |

## Verification
The sweep tests the pointer, the prefetch and the commit together:
- It writes a computed pattern to every address with auto-increment and reads all of it back.
- A pointer that skips, sticks or fails to wrap shows up as a wrong byte on `host_rdata` at the first affected address.
- A late or missing prefetch returns a stale byte on the first read after a pointer load.

For arbitration, an ordering fault is visible within a cycle or two:
- If the host wins while the network is requesting, `busy` clears early, or a byte the network has just written is read back stale.
- A wrong slot rate changes the grant pattern during a held network request.

// File: rtl/pbuf_pkg.sv
package pbuf_pkg;

   typedef enum logic [1:0] {
      SEL_DATA   = 2'd0,
      SEL_PTR_LO = 2'd1,
      SEL_PTR_HI = 2'd2,
      SEL_SETUP  = 2'd3
   } pbuf_sel_e;

   localparam int unsigned CTRL_DIR_BIT = 7;
   localparam int unsigned CTRL_INC_BIT = 6;
   localparam int unsigned SETUP_SLOW_BIT = 0;

endpackage

// File: rtl/pbuf_pointer.sv
module pbuf_pointer
   import pbuf_pkg::*;
#(
   parameter int unsigned ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_wr,
   input  logic              lo_wr,
   input  logic [7:0]        wdata,
   input  logic              adv,
   output logic [ADDR_W-1:0] ptr,
   output logic [ADDR_W-1:0] ptr_nxt,
   output logic              auto_inc,
   output logic              dir_rd,
   output logic              load_rd,
   output logic [7:0]        hi_rb,
   output logic [7:0]        lo_rb
);
   localparam int unsigned HI_W = ADDR_W - 8;
   localparam logic [ADDR_W-1:0] PTR_MAX = {ADDR_W{1'b1}};

   logic [HI_W-1:0] stg_hi;
   logic            stg_inc;
   logic            stg_dir;

   always_comb begin
      ptr_nxt = ptr;
      if (lo_wr) begin
         ptr_nxt = {stg_hi, wdata};
      end else if (adv && auto_inc) begin
         ptr_nxt = (ptr == PTR_MAX) ? '0 : ptr + ADDR_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_hi   <= '0;
         stg_inc  <= 1'b0;
         stg_dir  <= 1'b0;
         ptr      <= '0;
         auto_inc <= 1'b0;
         dir_rd   <= 1'b0;
      end else begin
         if (hi_wr) begin
            stg_hi  <= wdata[HI_W-1:0];
            stg_inc <= wdata[CTRL_INC_BIT];
            stg_dir <= wdata[CTRL_DIR_BIT];
         end
         if (lo_wr) begin
            auto_inc <= stg_inc;
            dir_rd   <= stg_dir;
         end
         ptr <= ptr_nxt;
      end
   end

   assign load_rd = lo_wr & stg_dir;

   always_comb begin
      hi_rb = '0;
      hi_rb[CTRL_DIR_BIT] = dir_rd;
      hi_rb[CTRL_INC_BIT] = auto_inc;
      hi_rb[HI_W-1:0]     = ptr[ADDR_W-1:8];
      lo_rb = ptr[7:0];
   end

   // R4: an auto-increment access moves the pointer up by one
   p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && auto_inc && ptr != PTR_MAX) |=> (ptr == $past(ptr) + ADDR_W'(1)));

   // R7: the top address wraps to zero
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && auto_inc && ptr == PTR_MAX) |=> (ptr == '0));

   // R6: without auto-increment the pointer holds
   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !auto_inc && !lo_wr) |=> $stable(ptr));

endmodule

// File: rtl/pbuf_arbiter.sv
module pbuf_arbiter #(
   parameter bit SLOW_ARB_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic slow_mode,
   input  logic net_req,
   input  logic host_req,
   output logic slot,
   output logic net_gnt,
   output logic host_gnt
);
   generate
      if (SLOW_ARB_EN) begin : g_slow
         logic phase_q;
         always_ff @(posedge clk) begin
            if (!rst_n) phase_q <= 1'b0;
            else        phase_q <= ~phase_q;
         end
         assign slot = slow_mode ? phase_q : 1'b1;
      end else begin : g_fast
         logic unused_slow;
         assign unused_slow = slow_mode;
         assign slot = 1'b1;
      end
   endgenerate

   assign net_gnt  = slot & net_req;
   assign host_gnt = slot & host_req & ~net_req;

   // R9: in slow mode no two slots are adjacent
   p_slow_alt_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (slow_mode && slot) |=> (!slot || !slow_mode));

endmodule

// File: rtl/pbuf_ram.sv
module pbuf_ram #(
   parameter int unsigned ADDR_W = 11,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

endmodule

// File: rtl/pbuf_port.sv
module pbuf_port
   import pbuf_pkg::*;
#(
   parameter int unsigned ADDR_W      = 11,
   parameter int unsigned DATA_W      = 8,
   parameter bit          SLOW_ARB_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        host_sel,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              busy,
   input  logic              net_req,
   input  logic              net_we,
   input  logic [ADDR_W-1:0] net_addr,
   input  logic [DATA_W-1:0] net_wdata,
   output logic              net_gnt,
   output logic [DATA_W-1:0] net_rdata
);
   initial begin
      a_addr_w: assert (ADDR_W >= 9 && ADDR_W <= 14)
         else $fatal(1, "ADDR_W must be 9..14");
      a_data_w: assert (DATA_W == 8)
         else $fatal(1, "DATA_W must be 8");
   end

   logic data_wr, data_rd, lo_wr, hi_wr, setup_wr, adv;
   logic [ADDR_W-1:0] ptr, ptr_nxt;
   logic auto_inc, dir_rd, load_rd;
   logic [7:0] hi_rb, lo_rb;
   logic [7:0] setup_q;
   logic slot, host_gnt;
   logic pend_q, pend_wr_q;
   logic [ADDR_W-1:0] pend_addr_q;
   logic [DATA_W-1:0] hold_q, net_rdata_q;
   logic ram_we;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_wdata, ram_rdata;

   assign data_wr  = host_wr && host_sel == SEL_DATA;
   assign data_rd  = host_rd && !host_wr && host_sel == SEL_DATA;
   assign lo_wr    = host_wr && host_sel == SEL_PTR_LO;
   assign hi_wr    = host_wr && host_sel == SEL_PTR_HI;
   assign setup_wr = host_wr && host_sel == SEL_SETUP;
   assign adv      = data_wr | data_rd;

   pbuf_pointer #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr), .lo_wr(lo_wr),
      .wdata(host_wdata), .adv(adv), .ptr(ptr), .ptr_nxt(ptr_nxt),
      .auto_inc(auto_inc), .dir_rd(dir_rd), .load_rd(load_rd),
      .hi_rb(hi_rb), .lo_rb(lo_rb)
   );

   pbuf_arbiter #(.SLOW_ARB_EN(SLOW_ARB_EN)) u_arb (
      .clk(clk), .rst_n(rst_n), .slow_mode(setup_q[SETUP_SLOW_BIT]),
      .net_req(net_req), .host_req(pend_q), .slot(slot),
      .net_gnt(net_gnt), .host_gnt(host_gnt)
   );

   always_comb begin
      if (net_gnt) begin
         ram_we    = net_we;
         ram_addr  = net_addr;
         ram_wdata = net_wdata;
      end else begin
         ram_we    = host_gnt & pend_wr_q;
         ram_addr  = pend_addr_q;
         ram_wdata = hold_q;
      end
   end

   pbuf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
      .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
      .rdata(ram_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         setup_q     <= '0;
         pend_q      <= 1'b0;
         pend_wr_q   <= 1'b0;
         pend_addr_q <= '0;
         hold_q      <= '0;
         net_rdata_q <= '0;
      end else begin
         if (setup_wr) setup_q <= host_wdata;
         if (net_gnt && !net_we) net_rdata_q <= ram_rdata;
         if (host_gnt) begin
            pend_q <= 1'b0;
            if (!pend_wr_q) hold_q <= ram_rdata;
         end
         if (data_wr) begin
            hold_q      <= host_wdata;
            pend_q      <= 1'b1;
            pend_wr_q   <= 1'b1;
            pend_addr_q <= ptr;
         end else if ((data_rd && dir_rd) || load_rd) begin
            pend_q      <= 1'b1;
            pend_wr_q   <= 1'b0;
            pend_addr_q <= ptr_nxt;
         end
      end
   end

   always_comb begin
      unique case (host_sel)
         SEL_DATA:   host_rdata = hold_q;
         SEL_PTR_LO: host_rdata = lo_rb;
         SEL_PTR_HI: host_rdata = hi_rb;
         default:    host_rdata = setup_q;
      endcase
   end

   assign busy      = pend_q;
   assign net_rdata = net_rdata_q;

   // R8: a network request in a slot keeps host work waiting
   p_net_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && net_req && slot) |=> busy);

   // R3: a pending host access in a free slot completes
   p_host_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && slot && !net_req && !host_wr && !host_rd) |=> !busy);

   // R5: a data write always leaves a commit pending
   p_commit_pend_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> busy);

   // R12: a write-direction load starts nothing when idle
   p_no_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !busy && !host_wdata[0] && !load_rd) |=> !busy);

endmodule

// File: tb/tb_pbuf_port.sv
module tb_pbuf_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] host_sel = 2'd0;
   logic host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = 8'd0;
   logic [7:0] host_rdata;
   logic busy;
   logic net_req = 1'b0, net_we = 1'b0;
   logic [10:0] net_addr = 11'd0;
   logic [7:0] net_wdata = 8'd0;
   logic net_gnt;
   logic [7:0] net_rdata;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pbuf_port dut (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .busy(busy), .net_req(net_req), .net_we(net_we), .net_addr(net_addr),
      .net_wdata(net_wdata), .net_gnt(net_gnt), .net_rdata(net_rdata)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + (a >> 8) * 11 + 5) & 255);
   endfunction

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic hwrite(int sel, int d);
      @(negedge clk);
      host_sel = 2'(sel); host_wdata = 8'(d); host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hread(int sel, output int d);
      @(negedge clk);
      host_sel = 2'(sel); host_rd = 1'b1;
      #1 d = int'(host_rdata);
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic peek(int sel, output int d);
      host_sel = 2'(sel);
      #1 d = int'(host_rdata);
   endtask

   task automatic load(int hi, int lo);
      hwrite(2, hi);
      hwrite(1, lo);
   endtask

   task automatic ptr_val(output int p);
      int h, l;
      peek(2, h); peek(1, l);
      p = ((h & 7) << 8) | l;
   endtask

   initial begin
      int v, p, g, prev, adj;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      peek(2, v); check("R1 ptr hi", v, 0);
      peek(1, v); check("R1 ptr lo", v, 0);
      peek(3, v); check("R1 setup", v, 0);
      check("R1 busy", int'(busy), 0);

      // R2 high write alone stages only
      hwrite(2, 8'hC5);
      peek(2, v); check("R2 hi staged only", v, 0);
      hwrite(1, 8'h3A);
      peek(2, v); check("R2 hi after lo", v, 8'hC5);
      peek(1, v); check("R2 lo after lo", v, 8'h3A);
      @(negedge clk);

      // R12 write-direction load: no prefetch
      load(8'h40, 8'h00);
      check("R12 busy after write load", int'(busy), 0);

      // R5/R7 sweep write of the whole buffer with auto-increment
      for (int a = 0; a < 2048; a++) hwrite(0, pat(a));
      @(negedge clk);
      check("R5 commit done", int'(busy), 0);
      ptr_val(p); check("R7 wrap after full write", p, 0);

      // R3/R4 sweep read of the whole buffer
      load(8'hC0, 8'h00);
      @(negedge clk);
      for (int a = 0; a < 2048; a++) begin
         hread(0, v);
         check($sformatf("R4 read addr %0d", a), v, pat(a));
      end

      // R7 wrap during read
      load(8'hC7, 8'hFE);
      @(negedge clk);
      hread(0, v); check("R7 read 0x7FE", v, pat(2046));
      hread(0, v); check("R7 read 0x7FF", v, pat(2047));
      hread(0, v); check("R7 read 0x000", v, pat(0));
      ptr_val(p); check("R7 ptr after wrap", p, 1);

      // R6 no auto-increment
      load(8'h81, 8'h23);
      @(negedge clk);
      hread(0, v); check("R6 first read", v, pat(291));
      hread(0, v); check("R6 second read", v, pat(291));
      ptr_val(p); check("R6 ptr held", p, 291);

      // R10 pointer readback counts a transfer
      load(8'h41, 8'h00);
      for (int k = 0; k < 5; k++) hwrite(0, 8'h90 + k);
      peek(2, v); check("R10 hi readback", v, 8'h41);
      peek(1, v); check("R10 lo readback", v, 8'h05);
      load(8'hC1, 8'h00);
      @(negedge clk);
      for (int k = 0; k < 5; k++) begin
         hread(0, v); check("R10 written bytes", v, 8'h90 + k);
      end

      // R8 network has priority over a pending prefetch
      @(negedge clk);
      net_req = 1'b1; net_we = 1'b1; net_addr = 11'h050; net_wdata = 8'hA5;
      load(8'h80, 8'h50);
      check("R8 busy held (1)", int'(busy), 1);
      @(negedge clk);
      check("R8 busy held (2)", int'(busy), 1);
      net_req = 1'b0; net_we = 1'b0;
      @(negedge clk);
      check("R8 busy after release", int'(busy), 0);
      hread(0, v); check("R8 read sees net write", v, 8'hA5);

      // R11 network read
      @(negedge clk);
      net_req = 1'b1; net_we = 1'b0; net_addr = 11'h123;
      #1 check("R11 grant", int'(net_gnt), 1);
      @(negedge clk);
      net_req = 1'b0;
      check("R11 net read data", int'(net_rdata), int'(pat(291)));

      // R9 fast mode: grant every cycle
      net_req = 1'b1; net_addr = 11'h000;
      g = 0;
      for (int c = 0; c < 6; c++) begin
         #1 g += int'(net_gnt);
         @(negedge clk);
      end
      check("R9 fast grants", g, 6);
      net_req = 1'b0;

      // R9 slow mode: alternate grants
      hwrite(3, 1);
      peek(3, v); check("R9 setup readback", v, 1);
      net_req = 1'b1;
      g = 0; adj = 0; prev = 0;
      for (int c = 0; c < 8; c++) begin
         #1;
         if (net_gnt && prev != 0) adj++;
         prev = int'(net_gnt);
         g += int'(net_gnt);
         @(negedge clk);
      end
      net_req = 1'b0;
      check("R9 slow grant count", g, 4);
      check("R9 slow adjacent grants", adj, 0);

      // R3 slow-mode prefetch still completes
      load(8'h80, 8'h07);
      repeat (2) @(negedge clk);
      check("R3 slow busy clear", int'(busy), 0);
      hread(0, v); check("R3 slow prefetch data", v, pat(7));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule